// File: doc/BRIEF.md
# Dual-Mode Timer with Prescaler and Postscaler

This block is a timer/counter for a control-oriented system. It counts prescaled ticks in one of two modes. In the wide mode it is a 16-bit counter that runs freely and wraps at the top of its range. In the short mode it is an 8-bit counter that returns to zero after it reaches a programmable period value. Each wrap or period match is an event. A programmable postscaler divides the events. When the postscaler completes, the block raises a sticky interrupt flag and drives a one-cycle output pulse.

Software reaches the block through a simple register port. One write strobe and one read address select three registers: control, period and count. The tick-enable input says on which clock cycles the prescaler may advance. The prescaler divides those enabled cycles by a power of two before the counter sees them.

Top module: `dualTimer`

## Requirements
- R1: After reset the control register reads 0, which means wide mode, prescale 1:1, postscale 1:1 and running. The period reads 0x00FF, the count reads 0, and `irqFlag` and `evtPulse` are low.
- R2: Control bits [3:0] set the prescale selector P. The counter receives one tick every 2^P enabled cycles, where an enabled cycle has `tickEn` high and the timer not halted. P=15 gives one tick per 32768 enabled cycles.
- R3: When control bit 8 is 0 (wide mode), each tick adds 1 to the 16-bit count. On a tick at 0xFFFF the count becomes 0x0000, and that wrap is an event.
- R4: When control bit 8 is 1 (short mode), a tick with count[7:0] equal to the period sets the count to 0, and that match is an event. Any other tick sets the count to {8'h00, count[7:0]+1}, so 0xFF wraps to 0 with no event.
- R5: Control bits [7:4] set the postscale selector N. Every N+1 events, `evtPulse` is high for one cycle and `irqFlag` sets. Both appear in the cycle that follows the clock edge where the count took the event value.
- R6: `irqFlag` stays set until `irqClr` is high at a clock edge. A new flag-setting event at the same edge wins over the clear.
- R7: A write to address 2 loads the count. A write to address 2 or address 0 clears the progress of the prescaler and the postscaler. A tick that would land on the same edge as either write is dropped.
- R8: Control bit 9 (halt) freezes the count, the prescaler and the postscaler without clearing them. Counting resumes from the frozen state when the bit is cleared.
- R9: Reads are combinational. Address 0 returns control[9:0], address 1 returns the period in bits [7:0], address 2 returns the count, and address 3 returns 0. A write to address 1 sets the period and leaves the count and both scalers untouched.
- R10: While `tickEn` is low and the count is not written, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 period, 2 count |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 16 | Read data for rdAddr |
| tickEn | input | 1 | Enables one prescaler step this cycle |
| irqClr | input | 1 | Clears the interrupt flag |
| irqFlag | output | 1 | Sticky interrupt flag |
| evtPulse | output | 1 | One-cycle pulse per completed postscale |

## Verification
The assertions check the following on every cycle:
- the flag holds until it is cleared;
- a pulse always comes with the flag set and a count of zero;
- a count write lands in the next cycle;
- the count stays still while halted or while no tick is enabled.

The exact tick spacing for each prescale setting, the period match in short mode, the N+1 event division, and the clearing of partial scaler progress by writes can only be seen over whole scenarios. The bench covers these with a cycle-by-cycle model, driven by directed corner cases and by seeded random traffic.

// File: rtl/dualTimerPkg.sv
package dualTimerPkg;

  // Write/read addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PER  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;     // one prescaled tick
    logic clrScal;  // clear postscaler progress
    logic ldCnt;    // load count from write data
  } strobe_t;

endpackage

// File: rtl/dualTimerCtrl.sv
module dualTimerCtrl
  import dualTimerPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SHORT_W = 8,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [CNT_W-1:0]   wrData,
  input  logic [1:0]         rdAddr,
  input  logic               tickEn,
  input  logic [CNT_W-1:0]   countIn,
  output logic [CNT_W-1:0]   rdData,
  output strobe_t            strb,
  output logic               mode8,
  output logic               halt,
  output logic [SEL_W-1:0]   postSel,
  output logic [SHORT_W-1:0] period
);

  localparam int PRE_W    = (1 << SEL_W) - 1;
  localparam int POST_LSB = SEL_W;
  localparam int MODE_BIT = 2 * SEL_W;
  localparam int HALT_BIT = 2 * SEL_W + 1;
  localparam int CTRL_W   = 2 * SEL_W + 2;

  logic [CTRL_W-1:0]  ctrlQ;
  logic [SHORT_W-1:0] periodQ;
  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W-1:0]   preLimit;
  logic [SEL_W-1:0]   preSel;
  logic               wrCtrl, wrPer, wrCnt, clrScal, preWrap, stepEn;

  assign preSel  = ctrlQ[SEL_W-1:0];
  assign postSel = ctrlQ[POST_LSB +: SEL_W];
  assign mode8   = ctrlQ[MODE_BIT];
  assign halt    = ctrlQ[HALT_BIT];
  assign period  = periodQ;

  assign wrCtrl  = wrEn && (wrAddr == ADDR_CTRL);
  assign wrPer   = wrEn && (wrAddr == ADDR_PER);
  assign wrCnt   = wrEn && (wrAddr == ADDR_CNT);
  assign clrScal = wrCtrl || wrCnt;

  // Terminal value of the prescaler: the low preSel bits set
  for (genvar g = 0; g < PRE_W; g++) begin : g_limit
    assign preLimit[g] = (32'(preSel) > g);
  end

  assign stepEn  = tickEn && !halt && !clrScal;
  assign preWrap = (preCnt == preLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      periodQ <= '1;
      preCnt  <= '0;
    end else begin
      if (wrCtrl) ctrlQ <= wrData[CTRL_W-1:0];
      if (wrPer)  periodQ <= wrData[SHORT_W-1:0];
      if (clrScal)     preCnt <= '0;
      else if (stepEn) preCnt <= preWrap ? '0 : preCnt + 1'b1;
    end
  end

  always_comb begin
    strb.tick    = stepEn && preWrap;
    strb.clrScal = clrScal;
    strb.ldCnt   = wrCnt;
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_CTRL: rdData = {{(CNT_W-CTRL_W){1'b0}}, ctrlQ};
      ADDR_PER:  rdData = {{(CNT_W-SHORT_W){1'b0}}, periodQ};
      ADDR_CNT:  rdData = countIn;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/dualTimerPath.sv
module dualTimerPath
  import dualTimerPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SHORT_W = 8,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [CNT_W-1:0]   ldVal,
  input  logic               mode8,
  input  logic [SEL_W-1:0]   postSel,
  input  logic [SHORT_W-1:0] period,
  input  logic               irqClr,
  output logic [CNT_W-1:0]   countQ,
  output logic               irqFlag,
  output logic               evtPulse
);

  localparam int HI_W = CNT_W - SHORT_W;

  logic [SHORT_W-1:0] lowQ;
  logic [SHORT_W-1:0] lowInc;
  logic [SEL_W-1:0]   postCnt;
  logic               matchHit, fullHit, evt, postDone;

  assign lowQ     = countQ[SHORT_W-1:0];
  assign lowInc   = lowQ + 1'b1;
  assign matchHit = (lowQ == period);
  assign fullHit  = &countQ;
  assign evt      = strb.tick && (mode8 ? matchHit : fullHit);
  assign postDone = evt && (postCnt == postSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ   <= '0;
      postCnt  <= '0;
      irqFlag  <= 1'b0;
      evtPulse <= 1'b0;
    end else begin
      if (strb.ldCnt) countQ <= ldVal;
      else if (strb.tick) begin
        if (mode8) countQ <= matchHit ? '0 : {{HI_W{1'b0}}, lowInc};
        else       countQ <= countQ + 1'b1;
      end

      if (strb.clrScal) postCnt <= '0;
      else if (evt)     postCnt <= postDone ? '0 : postCnt + 1'b1;

      if (postDone)    irqFlag <= 1'b1;
      else if (irqClr) irqFlag <= 1'b0;

      evtPulse <= postDone;
    end
  end

endmodule

// File: rtl/dualTimer.sv
module dualTimer
  import dualTimerPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SHORT_W = 8,
  parameter int SEL_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  input  logic             tickEn,
  input  logic             irqClr,
  output logic             irqFlag,
  output logic             evtPulse
);

  strobe_t            strb;
  logic               mode8, haltQ;
  logic [SEL_W-1:0]   postSel;
  logic [SHORT_W-1:0] period;
  logic [CNT_W-1:0]   countQ;

  dualTimerCtrl #(.CNT_W(CNT_W), .SHORT_W(SHORT_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .tickEn(tickEn), .countIn(countQ), .rdData(rdData),
    .strb(strb), .mode8(mode8), .halt(haltQ), .postSel(postSel), .period(period)
  );

  dualTimerPath #(.CNT_W(CNT_W), .SHORT_W(SHORT_W), .SEL_W(SEL_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .ldVal(wrData), .mode8(mode8),
    .postSel(postSel), .period(period), .irqClr(irqClr), .countQ(countQ),
    .irqFlag(irqFlag), .evtPulse(evtPulse)
  );

endmodule

// File: rtl/dualTimerChk.sv
module dualTimerChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic [CNT_W-1:0] wrData,
  input logic             tickEn,
  input logic             irqClr,
  input logic             irqFlag,
  input logic             evtPulse,
  input logic             haltQ,
  input logic [CNT_W-1:0] countQ
);

  logic cntWrite;
  assign cntWrite = wrEn && (wrAddr == 2'd2);

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqClr |=> (evtPulse || !irqFlag));

  // R5
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> irqFlag);

  // R3 R4
  pulse_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> (countQ == '0));

  // R7
  count_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWrite |=> (countQ == $past(wrData)));

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (haltQ && !cntWrite) |=> $stable(countQ));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !cntWrite) |=> $stable(countQ));

endmodule

bind dualTimer dualTimerChk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .tickEn(tickEn), .irqClr(irqClr), .irqFlag(irqFlag), .evtPulse(evtPulse),
  .haltQ(haltQ), .countQ(countQ)
);

// File: tb/dualTimer_bench.sv
`timescale 1ns/1ps
module dualTimer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic        tickEn = 1'b0;
  logic        irqClr = 1'b0;
  logic [15:0] rdData;
  logic        irqFlag, evtPulse;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dualTimer u_dualTimer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .tickEn(tickEn), .irqClr(irqClr),
    .irqFlag(irqFlag), .evtPulse(evtPulse)
  );

  // Reference model of the requirements
  logic [9:0]  mCtrl;
  logic [7:0]  mPer;
  logic [15:0] mCount;
  int          mPc, mPo;
  logic        mIrq, mEvt;

  task automatic modelReset();
    mCtrl = '0; mPer = 8'hFF; mCount = '0; mPc = 0; mPo = 0; mIrq = 0; mEvt = 0;
  endtask

  task automatic modelStep();
    logic setNow = 1'b0;
    logic ev = 1'b0;
    if (wrEn && (wrAddr == 2'd0 || wrAddr == 2'd2)) begin
      if (wrAddr == 2'd0) mCtrl = wrData[9:0];
      else mCount = wrData;
      mPc = 0; mPo = 0;
    end else begin
      if (tickEn && !mCtrl[9]) begin
        if (mPc == (1 << mCtrl[3:0]) - 1) begin
          mPc = 0;
          if (mCtrl[8]) begin
            if (mCount[7:0] == mPer) begin mCount = 0; ev = 1; end
            else mCount = {8'h00, mCount[7:0] + 8'h01};
          end else begin
            ev = (mCount == 16'hFFFF);
            mCount = mCount + 16'h1;
          end
          if (ev) begin
            if (mPo == int'(mCtrl[7:4])) begin mPo = 0; setNow = 1; end
            else mPo++;
          end
        end else mPc++;
      end
      if (wrEn && wrAddr == 2'd1) mPer = wrData[7:0];
    end
    if (setNow) mIrq = 1;
    else if (irqClr) mIrq = 0;
    mEvt = setNow;
  endtask

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else modelStep();
  end

  function automatic logic [15:0] expRead(logic [1:0] a);
    case (a)
      2'd0: return {6'h0, mCtrl};
      2'd1: return {8'h0, mPer};
      2'd2: return mCount;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Advance one cycle and compare the ports against the model
  task automatic step();
    @(negedge clk);
    chk("R2 R3 R4 R7 R8 R9 model rdData", rdData, expRead(rdAddr));
    chk("R5 R6 model irqFlag", {15'h0, irqFlag}, {15'h0, mIrq});
    chk("R5 model evtPulse", {15'h0, evtPulse}, {15'h0, mEvt});
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    step();
    wrEn = 0;
  endtask

  task automatic ticks(int n);
    tickEn = 1;
    repeat (n) step();
    tickEn = 0;
  endtask

  task automatic readChk(string tag, logic [1:0] a, logic [15:0] exp);
    rdAddr = a;
    #0.5;
    chk(tag, rdData, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    readChk("R1 ctrl", 2'd0, 16'h0000);
    readChk("R1 period", 2'd1, 16'h00FF);
    readChk("R1 count", 2'd2, 16'h0000);
    chk("R1 irqFlag", {15'h0, irqFlag}, 16'h0);
    chk("R1 evtPulse", {15'h0, evtPulse}, 16'h0);

    // R9 register map
    wr(2'd1, 16'h125A);
    readChk("R9 period", 2'd1, 16'h005A);
    readChk("R9 addr3", 2'd3, 16'h0000);
    wr(2'd0, 16'h0000);
    readChk("R9 ctrl", 2'd0, 16'h0000);

    // R3 wide wrap
    rdAddr = 2'd2;
    wr(2'd2, 16'hFFFE);
    ticks(1);
    chk("R3 before wrap", rdData, 16'hFFFF);
    chk("R3 no pulse yet", {15'h0, evtPulse}, 16'h0);
    ticks(1);
    chk("R3 wrapped", rdData, 16'h0000);
    chk("R5 pulse on wrap", {15'h0, evtPulse}, 16'h1);
    step();
    chk("R5 pulse one cycle", {15'h0, evtPulse}, 16'h0);
    // R6 hold then clear
    repeat (5) step();
    chk("R6 flag held", {15'h0, irqFlag}, 16'h1);
    irqClr = 1; step(); irqClr = 0;
    chk("R6 flag cleared", {15'h0, irqFlag}, 16'h0);

    // R10 idle
    wr(2'd2, 16'h0033);
    repeat (8) step();
    chk("R10 idle count", rdData, 16'h0033);

    // R2 largest prescale
    wr(2'd0, 16'h000F);
    wr(2'd2, 16'h0000);
    ticks(32767);
    chk("R2 1:32768 before", rdData, 16'h0000);
    ticks(1);
    chk("R2 1:32768 tick", rdData, 16'h0001);

    // R7 write clears prescaler progress (prescale 1:4)
    wr(2'd0, 16'h0002);
    ticks(3);
    wr(2'd2, 16'h000A);
    ticks(3);
    chk("R7 progress cleared", rdData, 16'h000A);
    ticks(1);
    chk("R7 tick after 4", rdData, 16'h000B);

    // R4 short mode, period 3
    wr(2'd0, 16'h0100);
    wr(2'd1, 16'h0003);
    wr(2'd2, 16'h0000);
    ticks(3);
    chk("R4 at period", rdData, 16'h0003);
    ticks(1);
    chk("R4 match clears", rdData, 16'h0000);
    chk("R4 match event", {15'h0, evtPulse}, 16'h1);
    // R4 above period wraps at 0xFF without event
    irqClr = 1; step(); irqClr = 0;
    wr(2'd2, 16'h12FF);
    ticks(1);
    chk("R4 wrap low byte", rdData, 16'h0000);
    chk("R4 wrap no event", {15'h0, evtPulse}, 16'h0);

    // R5 postscale 1:4, period 0: one event per tick
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0130);
    ticks(3);
    chk("R5 no flag after 3", {15'h0, irqFlag}, 16'h0);
    ticks(1);
    chk("R5 flag after 4", {15'h0, irqFlag}, 16'h1);
    chk("R5 pulse after 4", {15'h0, evtPulse}, 16'h1);

    // R8 halt freezes and resumes
    wr(2'd0, 16'h0100);
    wr(2'd1, 16'h0009);
    wr(2'd2, 16'h0004);
    wr(2'd0, 16'h0300);
    ticks(6);
    chk("R8 halted", rdData, 16'h0004);
    wr(2'd0, 16'h0100);
    ticks(2);
    chk("R8 resumed", rdData, 16'h0006);

    // Random traffic
    for (int i = 0; i < 20000; i++) begin
      int r = $urandom % 100;
      wrEn = 0;
      if (r < 6) begin
        wrEn = 1; wrAddr = 2'd0;
        wrData = {6'h0, ($urandom % 10 == 0), 1'($urandom), 4'($urandom % 4), 4'($urandom % 3)};
      end else if (r < 10) begin
        wrEn = 1; wrAddr = 2'd2;
        wrData = ($urandom % 2) ? 16'hFFF0 + 16'($urandom % 16) : 16'($urandom % 8);
      end else if (r < 13) begin
        wrEn = 1; wrAddr = 2'd1; wrData = 16'($urandom % 8);
      end else if (r < 15) begin
        wrEn = 1; wrAddr = 2'd3; wrData = 16'($urandom);
      end
      tickEn = ($urandom % 10) < 7;
      irqClr = ($urandom % 10) == 0;
      rdAddr = 2'($urandom);
      step();
    end
    wrEn = 0; tickEn = 0; irqClr = 0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule